// File: doc/BRIEF.md
# Ethernet alignment pad stripper

This block sits on the receive path between an internal 64-bit frame stream and a host processor. Inside the chip every Ethernet frame is carried with six empty bytes in front of the destination MAC address, so that the IP and UDP header fields land on 64-bit word boundaries. The host expects ordinary frames. The block removes the six leading bytes from each frame and shifts the remaining bytes across beat boundaries. It recomputes the byte count of the final beat and flags the first beat of each frame in the user sideband.

Both sides are AXI4-Stream with 64-bit data, a 4-bit user field and tlast. Byte lane 0 (bits 7:0) carries the earliest byte of a beat. On the last beat of a frame, user bits [2:0] hold the number of valid bytes, and 0 means all eight are valid. Each output beat is built from the upper two bytes of one input beat, held in a carry register, together with the lower six bytes of the following input beat.

A three-state controller sequences the work:
- PS_EMPTY: nothing is held. The first beat of a frame is absorbed into the carry register (EMPTY→MID). A one-beat frame instead goes EMPTY→TAIL when its count is 7 or 8, or stays in EMPTY otherwise.
- PS_MID: each accepted beat produces one output beat. The state stays in MID on a beat without tlast. On a final beat with 1 to 6 valid bytes it goes MID→EMPTY, and on a final beat with 7 or 8 it goes MID→TAIL.
- PS_TAIL: one extra beat is emitted from the carry register alone, with no input accepted. The state returns TAIL→EMPTY when that beat is taken.

Top module: `eth_pad_stripper`

## Requirements
- R1: After reset, m_tvalid is low and s_tready is high while no input is offered.
- R2: Output byte n of a frame (lane n mod 8 of output beat n/8, lane 0 earliest) equals input byte n+6 of the same frame; no byte is lost, duplicated or reordered.
- R3: m_tuser[3] is high on the first output beat of every frame and low on all its other beats.
- R4: When the input's last beat carries count c from 1 to 6 in s_tuser[2:0] (0 meaning 8), the output frame ends on the beat formed with that input beat, with m_tuser[2:0] = c+2 and a count of 8 written as 0.
- R5: When the input's last beat carries count 7 or 8, one extra output beat follows with m_tlast high and count 1 or 2. s_tready stays low while that beat is pending.
- R6: While m_tvalid is high and m_tready low, m_tdata, m_tuser and m_tlast hold their values into the next cycle. Arbitrary gaps on the input and stalls on the output change no output byte.
- R7: Output beats without m_tlast carry 0 in m_tuser[2:0].
- R8: Frames may follow each other with no idle cycle, and each one again begins with the start flag of R3.
- R9: s_tuser bit 3 and the count bits of non-last input beats have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | DATA_W | Padded input data |
| s_tuser | input | USER_W | Input sideband; [2:0] last-beat byte count |
| s_tlast | input | 1 | Last beat of input frame |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DATA_W | Realigned output data |
| m_tuser | output | USER_W | [3] start of frame, [2:0] last-beat byte count |
| m_tlast | output | 1 | Last beat of output frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |

## Verification
The assertions check on every cycle the properties that hold beat by beat. These are the idle output after reset, the held output under backpressure, the start flag appearing only on a frame's first beat, the zero count on non-final beats, and input being refused while a one- or two-byte trailing beat waits. Whether the bytes are actually shifted by six, and whether the final count is right for each input count from 1 to 8, can only be shown by the directed scenarios. Those scenarios compare every output byte with a model of the frame. The same applies to the claim that gaps and stalls neither lose nor repeat data across frame boundaries.

// File: rtl/padstrip_pkg.sv
package padstrip_pkg;

    // Controller states of the pad stripper
    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,   // no carry bytes held
        PS_MID   = 2'd1,   // carry bytes held, forwarding beats
        PS_TAIL  = 2'd2    // emitting the extra trailing beat
    } ps_state_e;

endpackage

// File: rtl/padstrip_count.sv
// Last-beat byte count arithmetic: decides whether the input frame ends
// within the current output beat and computes the resulting counts.
module padstrip_count #(
    parameter int BYTES     = 8,
    parameter int PAD_BYTES = 6,
    parameter int CW        = 3
) (
    input  logic [CW-1:0] cnt_in,     // input last-beat count, 0 = all lanes
    output logic          is_short,   // frame ends without an extra beat
    output logic [CW-1:0] short_cnt,  // count when ending on the current beat
    output logic [CW-1:0] tail_cnt    // count of the extra trailing beat
);

    localparam int CARRY = BYTES - PAD_BYTES;
    localparam logic [CW:0] BYTES_V = (CW+1)'(BYTES);
    localparam logic [CW:0] PAD_V   = (CW+1)'(PAD_BYTES);
    localparam logic [CW:0] CARRY_V = (CW+1)'(CARRY);

    logic [CW:0] full;

    always_comb begin
        full      = (cnt_in == '0) ? BYTES_V : {1'b0, cnt_in};
        is_short  = (full <= PAD_V);
        short_cnt = CW'(full + CARRY_V);
        tail_cnt  = CW'(full - PAD_V);
    end

endmodule

// File: rtl/padstrip_stage.sv
// One-beat staging storage: the upper carry bytes of the last accepted
// input beat, the start-of-frame flag and the pending trailing count.
module padstrip_stage #(
    parameter int CARRY_W = 16,
    parameter int CW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               first_d,
    input  logic [CARRY_W-1:0] carry_d,
    input  logic [CW-1:0]      tail_d,
    output logic [CARRY_W-1:0] carry_q,
    output logic               first_q,
    output logic [CW-1:0]      tail_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= '0;
            first_q <= 1'b0;
            tail_q  <= '0;
        end else if (load) begin
            carry_q <= carry_d;
            first_q <= first_d;
            tail_q  <= tail_d;
        end
    end

endmodule

// File: rtl/padstrip_ctrl.sv
// Controller of the pad stripper: state register, next state and outputs.
module padstrip_ctrl
    import padstrip_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_last,
    input  logic      in_short,
    input  logic      out_ready,
    output ps_state_e state,
    output logic      in_ready,
    output logic      out_valid,
    output logic      out_last,
    output logic      take_beat,
    output logic      first_beat
);

    ps_state_e state_q;
    ps_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_EMPTY: begin
                if (in_valid) begin
                    if (!in_last)      state_d = PS_MID;
                    else if (in_short) state_d = PS_EMPTY;
                    else               state_d = PS_TAIL;
                end
            end
            PS_MID: begin
                if (in_valid && out_ready && in_last) begin
                    state_d = in_short ? PS_EMPTY : PS_TAIL;
                end
            end
            PS_TAIL: begin
                if (out_ready) state_d = PS_EMPTY;
            end
            default: state_d = PS_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            PS_EMPTY: begin
                in_ready = 1'b1;
            end
            PS_MID: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_last  = in_last && in_short;
            end
            PS_TAIL: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
        take_beat  = in_valid && in_ready;
        first_beat = (state_q == PS_EMPTY);
        state      = state_q;
    end

endmodule

// File: rtl/eth_pad_stripper.sv
// Removes the leading alignment pad from each frame, realigns the data
// across beats, recomputes the final byte count and flags start of frame.
module eth_pad_stripper
    import padstrip_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int USER_W    = 4,
    parameter int PAD_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [USER_W-1:0] s_tuser,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [USER_W-1:0] m_tuser,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);

    localparam int BYTES   = DATA_W / 8;
    localparam int CW      = $clog2(BYTES);
    localparam int CARRY   = BYTES - PAD_BYTES;
    localparam int CARRY_W = CARRY * 8;
    localparam int SOF_BIT = USER_W - 1;

    ps_state_e           state;
    logic                take_beat;
    logic                first_beat;
    logic                is_short;
    logic [CW-1:0]       short_cnt;
    logic [CW-1:0]       tail_cnt;
    logic [CARRY_W-1:0]  carry_q;
    logic                first_q;
    logic [CW-1:0]       tail_q;

    // Sideband bits above the count field are not used on input
    logic unused_user_hi;
    assign unused_user_hi = ^s_tuser[USER_W-1:CW];

    padstrip_count #(
        .BYTES     (BYTES),
        .PAD_BYTES (PAD_BYTES),
        .CW        (CW)
    ) i_count (
        .cnt_in    (s_tuser[CW-1:0]),
        .is_short  (is_short),
        .short_cnt (short_cnt),
        .tail_cnt  (tail_cnt)
    );

    padstrip_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (s_tvalid),
        .in_last    (s_tlast),
        .in_short   (is_short),
        .out_ready  (m_tready),
        .state      (state),
        .in_ready   (s_tready),
        .out_valid  (m_tvalid),
        .out_last   (m_tlast),
        .take_beat  (take_beat),
        .first_beat (first_beat)
    );

    padstrip_stage #(
        .CARRY_W (CARRY_W),
        .CW      (CW)
    ) i_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (take_beat),
        .first_d (first_beat),
        .carry_d (s_tdata[DATA_W-1 -: CARRY_W]),
        .tail_d  (tail_cnt),
        .carry_q (carry_q),
        .first_q (first_q),
        .tail_q  (tail_q)
    );

    // Output lanes: low lanes from the carry register, the rest from the
    // lower lanes of the current input beat (zero on the trailing beat)
    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        if (j < CARRY) begin : g_carry
            assign m_tdata[8*j +: 8] = carry_q[8*j +: 8];
        end else begin : g_fwd
            assign m_tdata[8*j +: 8] = (state == PS_TAIL) ? 8'h00
                                     : s_tdata[8*(j-CARRY) +: 8];
        end
    end

    // Output sideband
    always_comb begin
        m_tuser          = '0;
        m_tuser[SOF_BIT] = first_q;
        unique case (state)
            PS_MID:   m_tuser[CW-1:0] = (s_tlast && is_short) ? short_cnt : '0;
            PS_TAIL:  m_tuser[CW-1:0] = tail_q;
            default:  m_tuser[CW-1:0] = '0;
        endcase
    end

endmodule

// File: rtl/padstrip_checker.sv
// Cycle-level properties of the pad stripper, bound to the top module.
module padstrip_checker #(
    parameter int DATA_W    = 64,
    parameter int USER_W    = 4,
    parameter int PAD_BYTES = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              s_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic [USER_W-1:0] m_tuser,
    input logic              m_tlast,
    input logic              m_tvalid,
    input logic              m_tready
);

    localparam int BYTES   = DATA_W / 8;
    localparam int CW      = $clog2(BYTES);
    localparam int SOF_BIT = USER_W - 1;
    localparam logic [CW-1:0] TAIL_MAX = CW'(BYTES - PAD_BYTES);

    // Observed position: high once a non-final output beat has been taken
    logic in_frame;
    always_ff @(posedge clk) begin
        if (rst)                       in_frame <= 1'b0;
        else if (m_tvalid && m_tready) in_frame <= !m_tlast;
    end

    // R1: output idle on the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !m_tvalid);

    // R3: start flag on the first beat of a frame
    a_r3_sof_on_first: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !in_frame) |-> m_tuser[SOF_BIT]);

    // R3: no start flag inside a frame
    a_r3_no_sof_inside: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && in_frame) |-> !m_tuser[SOF_BIT]);

    // R5: no input taken while the short trailing beat is pending
    a_r5_tail_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tlast && m_tuser[CW-1:0] != '0
         && m_tuser[CW-1:0] <= TAIL_MAX) |-> !s_tready);

    // R6: output held while stalled
    a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tuser) && $stable(m_tlast)));

    // R7: count field zero before the final beat
    a_r7_zero_count_midframe: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |-> (m_tuser[CW-1:0] == '0));

endmodule

bind eth_pad_stripper padstrip_checker #(
    .DATA_W    (DATA_W),
    .USER_W    (USER_W),
    .PAD_BYTES (PAD_BYTES)
) i_padstrip_checker (
    .clk      (clk),
    .rst      (rst),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready)
);

// File: tb/test_eth_pad_stripper.sv
`timescale 1ns/1ps
module test_eth_pad_stripper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] s_tdata = '0;
    logic [3:0]  s_tuser = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic [3:0]  m_tuser;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b1;

    always #2.5 clk = ~clk;   // 200 MHz

    eth_pad_stripper i_eth_pad_stripper (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Stimulus and expected-beat queues
    logic [63:0] qi_d[$];
    logic [3:0]  qi_u[$];
    logic        qi_l[$];
    logic [63:0] qe_d[$];
    int          qe_c[$];
    logic        qe_l[$];
    logic        qe_s[$];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Queue one frame of nbytes including the six pad bytes
    function automatic void add_frame(int nbytes, int tag);
        logic [7:0] fb[$];
        int nb, ob, nob;
        for (int i = 0; i < nbytes; i++)
            fb.push_back(i < 6 ? 8'hEE : 8'(tag * 29 + i * 7 + 1));
        nb = (nbytes + 7) / 8;
        for (int k = 0; k < nb; k++) begin
            logic [63:0] d;
            for (int j = 0; j < 8; j++)
                d[8*j +: 8] = (8*k + j < nbytes) ? fb[8*k + j] : 8'hA5;
            qi_d.push_back(d);
            qi_l.push_back(k == nb - 1);
            // R9: bit 3 and non-last counts carry junk
            if (k == nb - 1) qi_u.push_back({1'(tag), 3'(nbytes % 8)});
            else             qi_u.push_back(4'((k * 5 + tag) & 15));
        end
        ob  = nbytes - 6;
        nob = (ob + 7) / 8;
        for (int k = 0; k < nob; k++) begin
            logic [63:0] d;
            for (int j = 0; j < 8; j++)
                d[8*j +: 8] = (8*k + j + 6 < nbytes) ? fb[8*k + j + 6] : 8'h00;
            qe_d.push_back(d);
            qe_c.push_back(k == nob - 1 ? ob - 8 * (nob - 1) : 8);
            qe_l.push_back(k == nob - 1);
            qe_s.push_back(k == 0);
        end
    endfunction

    task automatic check_beat(int oi, string scen);
        logic [63:0] mask = '0;
        int cnt = qe_c[oi];
        string lreq;
        for (int j = 0; j < cnt; j++) mask[8*j +: 8] = 8'hFF;
        chk((m_tdata & mask) == (qe_d[oi] & mask), "R2", {scen, " data"},
            m_tdata & mask, qe_d[oi] & mask);
        chk(m_tuser[3] == qe_s[oi], "R3", {scen, " start flag"},
            64'(m_tuser[3]), 64'(qe_s[oi]));
        lreq = (qe_l[oi] && cnt <= 2) ? "R5" : "R4";
        chk(m_tlast == qe_l[oi], lreq, {scen, " last"}, 64'(m_tlast), 64'(qe_l[oi]));
        if (qe_l[oi])
            chk(m_tuser[2:0] == 3'(cnt % 8), lreq, {scen, " final count"},
                64'(m_tuser[2:0]), 64'(cnt % 8));
        else
            chk(m_tuser[2:0] == 3'd0, "R7", {scen, " mid count"},
                64'(m_tuser[2:0]), 64'd0);
    endtask

    // Drive all queued frames, collect and compare the output
    task automatic run_stream(string scen, bit gaps, bit stalls, int seed);
        int ii = 0, oi = 0, cyc = 0;
        bit vld = 1'b0;
        logic [15:0] lf = 16'(seed) | 16'd1;
        while ((ii < qi_d.size() || oi < qe_d.size()) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (!vld && ii < qi_d.size()) vld = !(gaps && lf[0]);
            s_tvalid = vld;
            if (ii < qi_d.size()) begin
                s_tdata = qi_d[ii]; s_tuser = qi_u[ii]; s_tlast = qi_l[ii];
            end
            m_tready = !(stalls && lf[3]);
            #1;
            if (m_tvalid && m_tready) begin
                if (oi < qe_d.size()) check_beat(oi, scen);
                else chk(1'b0, "R2", {scen, " extra beat"}, m_tdata, 64'd0);
                oi++;
            end
            if (m_tvalid && m_tlast && (m_tuser[2:0] == 3'd1 || m_tuser[2:0] == 3'd2))
                chk(!s_tready, "R5", {scen, " input blocked on tail"}, 64'(s_tready), 64'd0);
            if (s_tvalid && s_tready) begin
                ii++;
                vld = 1'b0;
            end
        end
        chk(oi == qe_d.size(), "R2", {scen, " beat total"}, 64'(oi), 64'(qe_d.size()));
        @(negedge clk);
        s_tvalid = 1'b0;
        m_tready = 1'b1;
        repeat (3) @(negedge clk);
        chk(!m_tvalid, "R2", {scen, " idle after stream"}, 64'(m_tvalid), 64'd0);
        qi_d.delete(); qi_u.delete(); qi_l.delete();
        qe_d.delete(); qe_c.delete(); qe_l.delete(); qe_s.delete();
    endtask

    task automatic test_reset();   // R1
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!m_tvalid, "R1", "valid after reset", 64'(m_tvalid), 64'd0);
        chk(s_tready, "R1", "ready after reset", 64'(s_tready), 64'd1);
    endtask

    task automatic test_short_tails();   // R4: final counts 1..6
        for (int c = 1; c <= 6; c++) add_frame(16 + c, c);
        add_frame(9, 7);
        add_frame(14, 8);
        run_stream("R4 short", 1'b0, 1'b0, 3);
    endtask

    task automatic test_long_tails();    // R5: final counts 7 and 8
        add_frame(15, 1);
        add_frame(16, 2);
        add_frame(23, 3);
        add_frame(24, 4);
        add_frame(64, 5);
        run_stream("R5 long", 1'b0, 1'b0, 5);
    endtask

    task automatic test_backpressure();  // R6: gaps and stalls
        for (int n = 9; n <= 40; n += 3) add_frame(n, n);
        run_stream("R6 stall", 1'b1, 1'b1, 77);
        add_frame(24, 9);
        add_frame(31, 10);
        add_frame(16, 11);
        run_stream("R6 stall only", 1'b0, 1'b1, 191);
    endtask

    task automatic test_back_to_back();  // R8
        for (int k = 0; k < 10; k++) add_frame(9 + (k % 4) * 2, 20 + k);
        run_stream("R8 back-to-back", 1'b0, 1'b0, 11);
    endtask

    task automatic test_sideband_ignored();   // R9
        add_frame(30, 1);
        add_frame(30, 2);
        add_frame(47, 3);
        add_frame(47, 4);
        run_stream("R9 sideband", 1'b1, 1'b0, 23);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_short_tails();
        test_long_tails();
        test_backpressure();
        test_back_to_back();
        test_sideband_ignored();
        finish_run();
    end

endmodule